// File: doc/BRIEF.md
# Chip-Select Timing Controller

This block drives the chip-select, output-enable and per-byte write-enable strobes of an external memory bus that is split into a set of banks. A request carries an address, an address type, a read/write flag and four byte-lane enables. The controller compares the address and type with each bank's base value under that bank's mask. It then runs the access with the timing attributes of the winning bank and ends it with a one-clock transfer-acknowledge pulse.

Each bank chooses how its access ends. With internal termination, the strobe phase has a fixed length set by a wait count; relaxed timing doubles that count. With external termination, an acknowledge input from the device ends the access, and acknowledges that arrive too early are ignored. Three further options are set per bank: one setup clock before the strobes, one hold clock after them, and one idle turnaround clock after a read. A write to a write-protected bank and a request that matches no bank both finish in a single clock with a status pulse, and no strobe is driven.

Until bank 0 is marked valid, bank 0 acts as a boot select. It matches every address with the slowest internal timing, so a boot ROM can be read before any bank is configured.

Top module: `cs_timing_ctrl`

## Requirements
- R1: A bank hits when `((req_addr ^ base) & mask) == 0`, `((req_type ^ type) & type_mask) == 0` and its valid bit is set. When several banks hit, the lowest index wins, and at most one `cs_n` bit is ever low.
- R2: A request that hits no bank drives no strobe and no `ta`. It raises `no_match` for exactly the one clock after acceptance.
- R3: With internal termination and relaxed timing off, the strobe phase lasts 2 + W clocks, where W is the bank's 4-bit wait count. `ta` is high in exactly one clock, the last strobe clock. `ext_ta` has no effect.
- R4: With internal termination and relaxed timing on, the strobe phase lasts 2 + 2·W clocks.
- R5: With external termination, the strobe phase lasts until `ext_ta` is seen high, and `ta` is high in that same clock. `ext_ta` is ignored in the first strobe clock, so the shortest strobe phase is 2 clocks.
- R6: With external termination and relaxed timing both on, `ext_ta` is ignored in the first two strobe clocks, so the shortest strobe phase is 3 clocks.
- R7: With the setup option set, `mem_aval` is high for one clock before the strobe phase, and all strobes are inactive in that clock.
- R8: With the hold option set, `mem_aval` stays high for one clock after the strobe phase, with all strobes inactive. No request is accepted in that clock.
- R9: After a read from a bank whose read-turnaround option is set, `req_ready` stays low for one clock unless the next request is a read that hits the same bank. If the option is clear, the next request is accepted in the first idle clock.
- R10: `oe_n` is low during the strobe phase of reads only. During the strobe phase of a write, `we_n[i]` is low exactly when `req_be[i]` was set.
- R11: A write to a write-protected bank drives no strobe and no `ta`. It raises `prot_err` for exactly the one clock after acceptance.
- R12: While `cfg_valid[0]` is low, bank 0 hits every address and type. It uses internal termination with W = 15, no options and no write protection, so the strobe phase lasts 17 clocks.
- R13: After reset all strobes are inactive and `req_ready` is high. `req_ready` is high only while no access is in progress, and never while `mem_aval` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this clock edge when high with `req_valid` |
| req_addr | input | ADDR_W | Request address |
| req_type | input | TYPE_W | Request address type |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte-lane enables of the request |
| cfg_valid | input | NUM_BANKS | Bank enabled; bank 0 low selects boot mode |
| cfg_base | input | NUM_BANKS*ADDR_W | Base address per bank |
| cfg_mask | input | NUM_BANKS*ADDR_W | Address compare mask per bank |
| cfg_type | input | NUM_BANKS*TYPE_W | Address type value per bank |
| cfg_type_mask | input | NUM_BANKS*TYPE_W | Address type compare mask per bank |
| cfg_waits | input | NUM_BANKS*4 | Wait count W per bank |
| cfg_relax | input | NUM_BANKS | Relaxed timing per bank |
| cfg_ext_ack | input | NUM_BANKS | External termination per bank |
| cfg_setup | input | NUM_BANKS | Setup clock before strobes per bank |
| cfg_hold | input | NUM_BANKS | Hold clock after strobes per bank |
| cfg_rd_hold | input | NUM_BANKS | Idle turnaround after reads per bank |
| cfg_wprot | input | NUM_BANKS | Write protection per bank |
| ext_ta | input | 1 | Transfer acknowledge from the external device |
| mem_addr | output | ADDR_W | Address of the current access |
| mem_aval | output | 1 | Address phase active (setup, strobe or hold clock) |
| cs_n | output | NUM_BANKS | Active-low chip selects |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 4 | Active-low byte write enables |
| ta | output | 1 | Transfer-acknowledge pulse |
| prot_err | output | 1 | Write-protect violation pulse |
| no_match | output | 1 | No-bank-hit pulse |

## Verification
The bench builds the controller with its defaults: four banks, a 32-bit address and a 3-bit address type. With four banks, two banks can overlap to test priority. The four banks also carry four different termination styles at once: internal, internal relaxed with setup, hold and protection, external, and external relaxed. The 4-bit wait count allows the 17-clock boot access and the doubled relaxed length to be measured clock by clock. Read-turnaround behaviour is tested with back-to-back requests, covering same-bank reads, other-bank accesses and missed accesses.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;

    localparam int LANES  = 4;
    localparam int WAIT_W = 4;
    localparam int CNT_W  = WAIT_W + 2;

    typedef struct packed {
        logic              ext_ack;
        logic              relax;
        logic              setup;
        logic              hold;
        logic              rd_hold;
        logic              wprot;
        logic [WAIT_W-1:0] waits;
    } bank_attr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_PROT,
        ST_MISS
    } cyc_state_t;

    localparam bank_attr_t BOOT_ATTR = '{
        ext_ack: 1'b0,
        relax:   1'b0,
        setup:   1'b0,
        hold:    1'b0,
        rd_hold: 1'b0,
        wprot:   1'b0,
        waits:   {WAIT_W{1'b1}}
    };

    // Strobe phase length with internal termination.
    function automatic logic [CNT_W-1:0] strobe_len(input bank_attr_t a);
        logic [CNT_W-1:0] w;
        w = a.relax ? {1'b0, a.waits, 1'b0} : {2'b00, a.waits};
        return CNT_W'(2) + w;
    endfunction

    // Shortest strobe phase with external termination.
    function automatic logic [CNT_W-1:0] ext_min(input bank_attr_t a);
        return a.relax ? CNT_W'(3) : CNT_W'(2);
    endfunction

endpackage

// File: rtl/cs_bank_decode.sv
module cs_bank_decode
    import cs_timing_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 32,
    parameter int TYPE_W    = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [TYPE_W-1:0]             req_type,
    input  logic [NUM_BANKS-1:0]          cfg_valid,
    input  logic [NUM_BANKS*ADDR_W-1:0]   cfg_base,
    input  logic [NUM_BANKS*ADDR_W-1:0]   cfg_mask,
    input  logic [NUM_BANKS*TYPE_W-1:0]   cfg_type,
    input  logic [NUM_BANKS*TYPE_W-1:0]   cfg_type_mask,
    input  bank_attr_t [NUM_BANKS-1:0]    attr_tab,
    output logic                          hit,
    output logic [BANK_W-1:0]             hit_bank,
    output bank_attr_t                    hit_attr
);

    logic       [NUM_BANKS-1:0] match;
    bank_attr_t [NUM_BANKS-1:0] attr_eff;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ADDR_W-1:0] base_b, mask_b;
        logic [TYPE_W-1:0] type_b, tmask_b;
        logic              cmp_ok;

        assign base_b  = cfg_base[b*ADDR_W +: ADDR_W];
        assign mask_b  = cfg_mask[b*ADDR_W +: ADDR_W];
        assign type_b  = cfg_type[b*TYPE_W +: TYPE_W];
        assign tmask_b = cfg_type_mask[b*TYPE_W +: TYPE_W];
        assign cmp_ok  = (((req_addr ^ base_b) & mask_b) == '0) &&
                         (((req_type ^ type_b) & tmask_b) == '0);

        if (b == 0) begin : g_boot
            // Boot select: unconfigured bank 0 claims everything.
            assign match[b]    = !cfg_valid[b] || cmp_ok;
            assign attr_eff[b] = cfg_valid[b] ? attr_tab[b] : BOOT_ATTR;
        end else begin : g_plain
            assign match[b]    = cfg_valid[b] && cmp_ok;
            assign attr_eff[b] = attr_tab[b];
        end
    end

    // Lowest index wins.
    always_comb begin
        hit      = 1'b0;
        hit_bank = '0;
        hit_attr = attr_eff[0];
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (match[b]) begin
                hit      = 1'b1;
                hit_bank = BANK_W'(b);
                hit_attr = attr_eff[b];
            end
        end
    end

endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer
    import cs_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  bank_attr_t attr,
    input  logic       ext_ta,
    output logic       done
);

    logic [CNT_W-1:0] cnt;

    // cnt equals the number of strobe clocks already completed.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        if (attr.ext_ack) begin
            done = run && ext_ta && (cnt >= (ext_min(attr) - CNT_W'(1)));
        end else begin
            done = run && (cnt == (strobe_len(attr) - CNT_W'(1)));
        end
    end

endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen
    import cs_timing_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  cyc_state_t           state,
    input  logic [BANK_W-1:0]    bank,
    input  logic                 write,
    input  logic [LANES-1:0]     be,
    output logic                 aval,
    output logic [NUM_BANKS-1:0] cs_n,
    output logic                 oe_n,
    output logic [LANES-1:0]     we_n
);

    logic strobe_on;

    assign strobe_on = (state == ST_ACCESS);
    assign aval      = (state == ST_SETUP) || (state == ST_ACCESS) || (state == ST_HOLD);
    assign oe_n      = !(strobe_on && !write);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign cs_n[b] = !(strobe_on && (bank == BANK_W'(b)));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_we
        assign we_n[l] = !(strobe_on && write && be[l]);
    end

endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl
    import cs_timing_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 32,
    parameter int TYPE_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [TYPE_W-1:0]             req_type,
    input  logic                          req_write,
    input  logic [LANES-1:0]              req_be,
    input  logic [NUM_BANKS-1:0]          cfg_valid,
    input  logic [NUM_BANKS*ADDR_W-1:0]   cfg_base,
    input  logic [NUM_BANKS*ADDR_W-1:0]   cfg_mask,
    input  logic [NUM_BANKS*TYPE_W-1:0]   cfg_type,
    input  logic [NUM_BANKS*TYPE_W-1:0]   cfg_type_mask,
    input  logic [NUM_BANKS*WAIT_W-1:0]   cfg_waits,
    input  logic [NUM_BANKS-1:0]          cfg_relax,
    input  logic [NUM_BANKS-1:0]          cfg_ext_ack,
    input  logic [NUM_BANKS-1:0]          cfg_setup,
    input  logic [NUM_BANKS-1:0]          cfg_hold,
    input  logic [NUM_BANKS-1:0]          cfg_rd_hold,
    input  logic [NUM_BANKS-1:0]          cfg_wprot,
    input  logic                          ext_ta,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          mem_aval,
    output logic [NUM_BANKS-1:0]          cs_n,
    output logic                          oe_n,
    output logic [LANES-1:0]              we_n,
    output logic                          ta,
    output logic                          prot_err,
    output logic                          no_match
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    bank_attr_t [NUM_BANKS-1:0] attr_tab;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_attr
        assign attr_tab[b] = '{
            ext_ack: cfg_ext_ack[b],
            relax:   cfg_relax[b],
            setup:   cfg_setup[b],
            hold:    cfg_hold[b],
            rd_hold: cfg_rd_hold[b],
            wprot:   cfg_wprot[b],
            waits:   cfg_waits[b*WAIT_W +: WAIT_W]
        };
    end

    logic              hit;
    logic [BANK_W-1:0] hit_bank;
    bank_attr_t        hit_attr;

    cs_bank_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .TYPE_W    (TYPE_W)
    ) i_decode (
        .req_addr      (req_addr),
        .req_type      (req_type),
        .cfg_valid     (cfg_valid),
        .cfg_base      (cfg_base),
        .cfg_mask      (cfg_mask),
        .cfg_type      (cfg_type),
        .cfg_type_mask (cfg_type_mask),
        .attr_tab      (attr_tab),
        .hit           (hit),
        .hit_bank      (hit_bank),
        .hit_attr      (hit_attr)
    );

    cyc_state_t        state, state_nx;
    logic [BANK_W-1:0] cur_bank, last_bank;
    bank_attr_t        cur_attr;
    logic              cur_write;
    logic [LANES-1:0]  cur_be;
    logic [ADDR_W-1:0] cur_addr;
    logic              turn_pend;
    logic              strobe_done;
    logic              same_rd;
    logic              accept;
    logic              cyc_end;

    cs_wait_timer i_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_ACCESS),
        .attr   (cur_attr),
        .ext_ta (ext_ta),
        .done   (strobe_done)
    );

    // Turnaround is waived only for a read that hits the same bank again.
    assign same_rd   = hit && !req_write && (hit_bank == last_bank);
    assign req_ready = (state == ST_IDLE) && !(turn_pend && !same_rd);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_nx = state;
        cyc_end  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!hit) begin
                        state_nx = ST_MISS;
                    end else if (req_write && hit_attr.wprot) begin
                        state_nx = ST_PROT;
                    end else if (hit_attr.setup) begin
                        state_nx = ST_SETUP;
                    end else begin
                        state_nx = ST_ACCESS;
                    end
                end
            end
            ST_SETUP: state_nx = ST_ACCESS;
            ST_ACCESS: begin
                if (strobe_done) begin
                    if (cur_attr.hold) begin
                        state_nx = ST_HOLD;
                    end else begin
                        state_nx = ST_IDLE;
                        cyc_end  = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                state_nx = ST_IDLE;
                cyc_end  = 1'b1;
            end
            ST_PROT: state_nx = ST_IDLE;
            ST_MISS: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_bank  <= '0;
            last_bank <= '0;
            cur_attr  <= BOOT_ATTR;
            cur_write <= 1'b0;
            cur_be    <= '0;
            cur_addr  <= '0;
            turn_pend <= 1'b0;
        end else begin
            state     <= state_nx;
            turn_pend <= cyc_end && !cur_write && cur_attr.rd_hold;
            if (cyc_end) begin
                last_bank <= cur_bank;
            end
            if (accept) begin
                cur_bank  <= hit_bank;
                cur_attr  <= hit_attr;
                cur_write <= req_write;
                cur_be    <= req_be;
                cur_addr  <= req_addr;
            end
        end
    end

    cs_strobe_gen #(
        .NUM_BANKS (NUM_BANKS)
    ) i_strobe (
        .state (state),
        .bank  (cur_bank),
        .write (cur_write),
        .be    (cur_be),
        .aval  (mem_aval),
        .cs_n  (cs_n),
        .oe_n  (oe_n),
        .we_n  (we_n)
    );

    assign mem_addr = cur_addr;
    assign ta       = (state == ST_ACCESS) && strobe_done;
    assign prot_err = (state == ST_PROT);
    assign no_match = (state == ST_MISS);

endmodule

// File: rtl/cs_timing_checker.sv
module cs_timing_checker #(
    parameter int NUM_BANKS = 4,
    parameter int LANES     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_ready,
    input logic                 mem_aval,
    input logic [NUM_BANKS-1:0] cs_n,
    input logic                 oe_n,
    input logic [LANES-1:0]     we_n,
    input logic                 ta,
    input logic                 prot_err,
    input logic                 no_match
);

    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        no_match |-> ((&cs_n) && !ta && (&we_n) && oe_n));

    assert_ta_in_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ta |-> ($countones(~cs_n) == 1));

    assert_ta_single_R3: assert property (@(posedge clk) disable iff (rst)
        ta |=> !ta);

    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ta |=> (!mem_aval || ((&cs_n) && oe_n && (&we_n))));

    assert_oe_read_R10: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> ((&we_n) && !(&cs_n)));

    assert_we_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(&we_n) |-> !(&cs_n));

    assert_prot_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        prot_err |-> ((&cs_n) && (&we_n) && !ta && !no_match));

    assert_busy_R13: assert property (@(posedge clk) disable iff (rst)
        mem_aval |-> !req_ready);

    assert_strobe_aval_R13: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n) |-> mem_aval);

endmodule

bind cs_timing_ctrl cs_timing_checker #(
    .NUM_BANKS (NUM_BANKS),
    .LANES     (cs_timing_pkg::LANES)
) i_checker (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mem_aval  (mem_aval),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .ta        (ta),
    .prot_err  (prot_err),
    .no_match  (no_match)
);

// File: tb/test_cs_timing_ctrl.sv
module test_cs_timing_ctrl;
    import cs_timing_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int AW = 32;
    localparam int TW = 3;

    typedef struct packed {
        logic [31:0] addr;
        logic [2:0]  atype;
        logic        wr;
        logic [3:0]  be;
        logic [7:0]  ext_from;  // clock index since accept, 0 = never
        logic [3:0]  bank;      // 15 = no strobe expected
        logic [3:0]  setup;
        logic [7:0]  len;
        logic [3:0]  hold;
        logic        oe;
        logic [3:0]  we;        // active-high lane mask
        logic        prot;
        logic        miss;
        logic [3:0]  wait_c;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 3'd0, 1'b0, 4'h0, 8'd0, 4'd0,  4'd0, 8'd5, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h0000_0200, 3'd0, 1'b1, 4'h5, 8'd0, 4'd0,  4'd0, 8'd5, 4'd0, 1'b0, 4'h5, 1'b0, 1'b0, 4'd0},
        '{32'h1000_0000, 3'd2, 1'b0, 4'h0, 8'd0, 4'd1,  4'd1, 8'd6, 4'd1, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h1000_0004, 3'd2, 1'b1, 4'hF, 8'd0, 4'd15, 4'd0, 8'd0, 4'd0, 1'b0, 4'h0, 1'b1, 1'b0, 4'd0},
        '{32'h1000_0000, 3'd0, 1'b0, 4'h0, 8'd0, 4'd15, 4'd0, 8'd0, 4'd0, 1'b0, 4'h0, 1'b0, 1'b1, 4'd0},
        '{32'h5000_0000, 3'd0, 1'b0, 4'h0, 8'd0, 4'd15, 4'd0, 8'd0, 4'd0, 1'b0, 4'h0, 1'b0, 1'b1, 4'd0},
        '{32'h2000_1000, 3'd0, 1'b0, 4'h0, 8'd4, 4'd2,  4'd0, 8'd4, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h2000_2000, 3'd0, 1'b0, 4'h0, 8'd1, 4'd2,  4'd0, 8'd2, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h0000_0000, 3'd0, 1'b0, 4'h0, 8'd0, 4'd0,  4'd0, 8'd5, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd1},
        '{32'h2100_0000, 3'd0, 1'b0, 4'h0, 8'd1, 4'd3,  4'd0, 8'd3, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h2000_0010, 3'd0, 1'b1, 4'hF, 8'd2, 4'd2,  4'd0, 8'd2, 4'd0, 1'b0, 4'hF, 1'b0, 1'b0, 4'd0},
        '{32'h2000_0000, 3'd0, 1'b0, 4'h0, 8'd3, 4'd2,  4'd0, 8'd3, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h0000_0010, 3'd0, 1'b1, 4'h8, 8'd0, 4'd0,  4'd0, 8'd5, 4'd0, 1'b0, 4'h8, 1'b0, 1'b0, 4'd1},
        '{32'h2100_0000, 3'd0, 1'b0, 4'h0, 8'd5, 4'd3,  4'd0, 8'd5, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h0000_0300, 3'd0, 1'b0, 4'h0, 8'd1, 4'd0,  4'd0, 8'd5, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h2000_0000, 3'd0, 1'b0, 4'h0, 8'd2, 4'd2,  4'd0, 8'd2, 4'd0, 1'b1, 4'h0, 1'b0, 1'b0, 4'd0},
        '{32'h5000_0000, 3'd0, 1'b0, 4'h0, 8'd0, 4'd15, 4'd0, 8'd0, 4'd0, 1'b0, 4'h0, 1'b0, 1'b1, 4'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_type = '0;
    logic req_write = 1'b0;
    logic [3:0] req_be = '0;
    logic [NB-1:0] cfg_valid = '0;
    logic [NB*AW-1:0] cfg_base = '0;
    logic [NB*AW-1:0] cfg_mask = '0;
    logic [NB*TW-1:0] cfg_type = '0;
    logic [NB*TW-1:0] cfg_type_mask = '0;
    logic [NB*WAIT_W-1:0] cfg_waits = '0;
    logic [NB-1:0] cfg_relax = '0, cfg_ext_ack = '0, cfg_setup = '0;
    logic [NB-1:0] cfg_hold = '0, cfg_rd_hold = '0, cfg_wprot = '0;
    logic ext_ta = 1'b0;
    logic [AW-1:0] mem_addr;
    logic mem_aval;
    logic [NB-1:0] cs_n;
    logic oe_n;
    logic [3:0] we_n;
    logic ta, prot_err, no_match;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_timing_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .TYPE_W(TW)) i_cs_timing_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_type(req_type), .req_write(req_write), .req_be(req_be),
        .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_type(cfg_type), .cfg_type_mask(cfg_type_mask), .cfg_waits(cfg_waits),
        .cfg_relax(cfg_relax), .cfg_ext_ack(cfg_ext_ack), .cfg_setup(cfg_setup),
        .cfg_hold(cfg_hold), .cfg_rd_hold(cfg_rd_hold), .cfg_wprot(cfg_wprot),
        .ext_ta(ext_ta), .mem_addr(mem_addr), .mem_aval(mem_aval), .cs_n(cs_n),
        .oe_n(oe_n), .we_n(we_n), .ta(ta), .prot_err(prot_err), .no_match(no_match)
    );

    task automatic check(input string tag, input string what, input int idx,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s vec %0d: actual %0d expected %0d", tag, what, idx, act, exp);
        end
    endtask

    task automatic do_access(input vec_t v, input int idx, input bit boot);
        int   waits = 0;
        int   setup = 0;
        int   cs_len = 0;
        int   ta_pos = 0;
        int   ta_cnt = 0;
        int   hold = 0;
        int   bank = 15;
        int   exp_ta_cnt;
        bit   oe_seen = 1'b0;
        bit   prot_seen = 1'b0;
        bit   miss_seen = 1'b0;
        bit   busy_rdy = 1'b0;
        logic [3:0] we_seen = '0;
        req_addr  = v.addr;
        req_type  = v.atype;
        req_write = v.wr;
        req_be    = v.be;
        req_valid = 1'b1;
        #1;
        while (!req_ready && waits < 8) begin
            waits++;
            @(posedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        for (int c = 1; c <= 64; c++) begin
            if (c > 1) begin
                @(posedge clk);
                #1;
            end
            ext_ta = (v.ext_from != 0) && (c >= int'(v.ext_from)) && (ta_cnt == 0);
            @(negedge clk);
            if (mem_aval && req_ready) busy_rdy = 1'b1;
            if (!(&cs_n)) begin
                cs_len++;
                for (int b = 0; b < NB; b++) if (!cs_n[b]) bank = b;
            end else if (mem_aval && cs_len == 0) begin
                setup++;
            end else if (mem_aval) begin
                hold++;
            end
            if (ta) begin
                ta_cnt++;
                if (ta_cnt == 1) ta_pos = cs_len;
            end
            if (!oe_n) oe_seen = 1'b1;
            we_seen = we_seen | ~we_n;
            if (prot_err) prot_seen = 1'b1;
            if (no_match) miss_seen = 1'b1;
            if (!mem_aval && !prot_err && !no_match) break;
        end
        ext_ta = 1'b0;
        exp_ta_cnt = (v.len != 0) ? 1 : 0;
        check(boot ? "R12/R1" : "R1", "bank", idx, bank, int'(v.bank));
        check(boot ? "R12" : "R3/R4/R5/R6", "strobe length", idx, cs_len, int'(v.len));
        check("R3", "ta position", idx, ta_pos, int'(v.len));
        check("R3", "ta count", idx, ta_cnt, exp_ta_cnt);
        check("R7", "setup clocks", idx, setup, int'(v.setup));
        check("R8", "hold clocks", idx, hold, int'(v.hold));
        check("R10", "oe seen", idx, int'(oe_seen), int'(v.oe));
        check("R10", "we lanes", idx, int'(we_seen), int'(v.we));
        check("R11", "prot pulse", idx, int'(prot_seen), int'(v.prot));
        check("R2", "no_match pulse", idx, int'(miss_seen), int'(v.miss));
        check("R9", "turnaround wait", idx, waits, int'(v.wait_c));
        check("R13", "ready while busy", idx, int'(busy_rdy), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        vec_t boot_v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        check("R13", "cs_n after reset", -1, int'(cs_n), 15);
        check("R13", "oe_n/we_n after reset", -1, int'({oe_n, we_n}), 31);
        check("R13", "pulses after reset", -1, int'({ta, prot_err, no_match, mem_aval}), 0);
        check("R13", "ready after reset", -1, int'(req_ready), 1);

        // R12: boot select with nothing configured
        boot_v = '{32'h7000_0040, 3'd5, 1'b0, 4'h0, 8'd0, 4'd0, 4'd0, 8'd17, 4'd0,
                   1'b1, 4'h0, 1'b0, 1'b0, 4'd0};
        do_access(boot_v, 100, 1'b1);
        boot_v = '{32'hF000_0000, 3'd1, 1'b1, 4'h3, 8'd0, 4'd0, 4'd0, 8'd17, 4'd0,
                   1'b0, 4'h3, 1'b0, 1'b0, 4'd0};
        do_access(boot_v, 101, 1'b1);

        // Bank configuration
        cfg_base      = {32'h2000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000};
        cfg_mask      = {32'hF000_0000, 32'hFF00_0000, 32'hF000_0000, 32'hFFF0_0000};
        cfg_type      = {3'd0, 3'd0, 3'd2, 3'd0};
        cfg_type_mask = {3'd0, 3'd0, 3'b111, 3'd0};
        cfg_waits     = {4'd0, 4'd0, 4'd2, 4'd3};
        cfg_relax     = 4'b1010;
        cfg_ext_ack   = 4'b1100;
        cfg_setup     = 4'b0010;
        cfg_hold      = 4'b0010;
        cfg_rd_hold   = 4'b0100;
        cfg_wprot     = 4'b0010;
        cfg_valid     = 4'b1111;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            do_access(VECS[i], i, 1'b0);
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule